// File: doc/BRIEF.md
# Shadowed Configuration Integrity Monitor

This block holds the configuration registers of a few error groups behind a simple register bus. Every group keeps two copies of its configuration: a primary copy that software reads, and a redundant shadow copy that is never visible on the bus. The two copies are compared on every clock. Any disagreement, such as a flipped bit in one copy, marks that group in a configuration-error raw status vector.

Software chooses which groups may raise the configuration-error interrupt. A group that is both marked and enabled drives a level interrupt. A one-clock pulse accompanies a new pending condition. The pulse also follows a write-one-to-clear that leaves other enabled groups still pending.

To repair a group, software rewrites any of that group's configuration registers, which reloads both copies together, and then clears the status bit. A status bit whose mismatch is still present survives the clear. A test input flips chosen bits of one group's shadow enable copy, so the detection path can be exercised.

Top module: `cfg_shadow_guard`

## Requirements
- R1: After synchronous reset, every register reads 0, and both `cfg_irq_level` and `cfg_irq_pulse` are 0.
- R2: Group g has a window at 0x400 + g*0x20. Writing +0x00 ORs data into the event register. Writing +0x08 ORs data into the enable register. Writing +0x0C clears the enable bits that are written as 1. Both +0x08 and +0x0C read back the enable register. Writing +0x10 loads the priority register, which reads back at +0x10. Writing +0x14 ORs data into the pin-influence register and writing +0x18 clears its 1-bits; both addresses read it back. None of these writes causes a mismatch.
- R3: An injection (`inj_valid`=1, group `inj_grp`, nonzero `inj_mask`) sets bit `inj_grp` of the raw status at 0x010 on the second rising edge after the injection edge. The other groups' bits are unaffected.
- R4: Writing 0x018 ORs data bits [NGRP-1:0] into the enable vector, which reads back at 0x018. Enable bits never clear. Address 0x014 reads raw AND enable.
- R5: Writing any configuration register of a group (+0x08, +0x0C, +0x10, +0x14 or +0x18) reloads the shadow from the primary copy and removes the mismatch. A later write of 1 to that group's bit at 0x014 then leaves its raw bit at 0.
- R6: A write of 1 to a group's bit at 0x014 while that group's mismatch is still present leaves the raw bit at 1.
- R7: `cfg_irq_level` is 1 exactly when raw AND enable is nonzero. A marked group that is not enabled leaves the level at 0.
- R8: `cfg_irq_pulse` is high for one clock, aligned with the level. It fires when the enabled pending set goes from empty to non-empty. It does not fire when bits are added to an already non-empty set.
- R9: A write to 0x014 that leaves enabled bits still pending produces a pulse. One that leaves none pending produces no pulse, and the level falls.
- R10: Writing 0x010 ORs data bits [NGRP-1:0] into the raw status.
- R11: When an injection and a configuration write to the same group fall in the same cycle, the primary copy takes the written value. The shadow takes that value XOR the mask, so the mismatch remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| inj_valid | input | 1 | Apply the test flip this cycle |
| inj_grp | input | 2 | Group whose shadow enable is flipped |
| inj_mask | input | 32 | Bits to flip in that shadow enable |
| cfg_irq_level | output | 1 | Level configuration-error interrupt |
| cfg_irq_pulse | output | 1 | One-clock configuration-error pulse |

## Verification
A write-one-to-clear of a status bit can land in the same cycle as a live mismatch of that group. The live mismatch must win: the bit stays set, and a fresh pulse is expected. The bench provokes this by injecting a flip and then clearing before the group is repaired. The second collision is an injection in the very cycle a configuration write reaches the same group. The bench judges it by reading the primary copy back unchanged while the raw status still marks the group.

// File: rtl/csg_pkg.sv
package csg_pkg;

    localparam int DW         = 32;
    localparam int AW         = 12;
    localparam int WIN_STRIDE = 32;

    localparam logic [AW-1:0] A_RAW  = 12'h010;
    localparam logic [AW-1:0] A_PEND = 12'h014;
    localparam logic [AW-1:0] A_EN   = 12'h018;
    localparam logic [AW-1:0] A_WIN  = 12'h400;

    typedef enum logic [2:0] {
        GR_EVT,
        GR_ENSET,
        GR_ENCLR,
        GR_PRI,
        GR_PINSET,
        GR_PINCLR,
        GR_NONE
    } greg_e;

    typedef struct packed {
        logic [DW-1:0] en;
        logic [DW-1:0] pri;
        logic [DW-1:0] pin;
    } gcfg_t;

    function automatic greg_e decode_greg(input logic [4:0] off);
        case (off)
            5'h00:   return GR_EVT;
            5'h08:   return GR_ENSET;
            5'h0C:   return GR_ENCLR;
            5'h10:   return GR_PRI;
            5'h14:   return GR_PINSET;
            5'h18:   return GR_PINCLR;
            default: return GR_NONE;
        endcase
    endfunction

endpackage

// File: rtl/csg_group.sv
module csg_group
    import csg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [4:0]    off,
    input  logic [DW-1:0] wdata,
    input  logic          inj_en,
    input  logic [DW-1:0] inj_mask,
    output logic [DW-1:0] rdata,
    output logic          mismatch
);

    gcfg_t         prim_q, prim_n;
    gcfg_t         shad_q, shad_n;
    logic [DW-1:0] evt_q;
    greg_e         sel;
    logic          cfg_wr;

    always_comb begin
        sel    = decode_greg(off);
        prim_n = prim_q;
        cfg_wr = 1'b0;
        if (wr_en) begin
            case (sel)
                GR_ENSET:  begin prim_n.en  = prim_q.en  |  wdata; cfg_wr = 1'b1; end
                GR_ENCLR:  begin prim_n.en  = prim_q.en  & ~wdata; cfg_wr = 1'b1; end
                GR_PRI:    begin prim_n.pri = wdata;               cfg_wr = 1'b1; end
                GR_PINSET: begin prim_n.pin = prim_q.pin |  wdata; cfg_wr = 1'b1; end
                GR_PINCLR: begin prim_n.pin = prim_q.pin & ~wdata; cfg_wr = 1'b1; end
                default:   ;
            endcase
        end
        // a configuration write reloads the whole shadow; a test flip lands on top
        shad_n = cfg_wr ? prim_n : shad_q;
        if (inj_en) shad_n.en = shad_n.en ^ inj_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q <= '0;
            shad_q <= '0;
            evt_q  <= '0;
        end else begin
            prim_q <= prim_n;
            shad_q <= shad_n;
            if (wr_en && sel == GR_EVT) evt_q <= evt_q | wdata;
        end
    end

    always_comb begin
        case (sel)
            GR_EVT:              rdata = evt_q;
            GR_ENSET, GR_ENCLR:  rdata = prim_q.en;
            GR_PRI:              rdata = prim_q.pri;
            GR_PINSET, GR_PINCLR: rdata = prim_q.pin;
            default:             rdata = '0;
        endcase
    end

    assign mismatch = (prim_q != shad_q);

endmodule

// File: rtl/csg_irq.sv
module csg_irq #(
    parameter int NGRP = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            raw_set_wr,
    input  logic            pend_clr_wr,
    input  logic            en_set_wr,
    input  logic [NGRP-1:0] wbits,
    input  logic [NGRP-1:0] mismatch,
    output logic [NGRP-1:0] raw_q,
    output logic [NGRP-1:0] en_q,
    output logic            level,
    output logic            pulse
);

    logic [NGRP-1:0] raw_n, en_n, pend_q, pend_n;
    logic            pulse_n;

    always_comb begin
        // a live mismatch overrides a clear in the same cycle
        raw_n   = (raw_q & ~(pend_clr_wr ? wbits : '0))
                | mismatch
                | (raw_set_wr ? wbits : '0);
        en_n    = en_q | (en_set_wr ? wbits : '0);
        pend_q  = raw_q & en_q;
        pend_n  = raw_n & en_n;
        pulse_n = (pend_n != '0) && ((pend_q == '0) || pend_clr_wr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
            en_q  <= '0;
            pulse <= 1'b0;
        end else begin
            raw_q <= raw_n;
            en_q  <= en_n;
            pulse <= pulse_n;
        end
    end

    assign level = (pend_q != '0);

endmodule

// File: rtl/cfg_shadow_guard.sv
module cfg_shadow_guard
    import csg_pkg::*;
#(
    parameter int NGRP = 4,
    localparam int GW  = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          inj_valid,
    input  logic [GW-1:0] inj_grp,
    input  logic [DW-1:0] inj_mask,
    output logic          cfg_irq_level,
    output logic          cfg_irq_pulse
);

    localparam logic [AW-1:0] WIN_SPAN = AW'(NGRP * WIN_STRIDE);

    logic [AW-1:0]   off_full;
    logic            in_win;
    logic [GW-1:0]   widx;
    logic [DW-1:0]   grd [NGRP];
    logic [NGRP-1:0] mismatch;
    logic [NGRP-1:0] raw_q, en_q;

    assign off_full = bus_addr - A_WIN;
    assign in_win   = (bus_addr >= A_WIN) && (off_full < WIN_SPAN);
    assign widx     = off_full[5 +: GW];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        csg_group u_grp (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (bus_wr && in_win && (widx == GW'(g))),
            .off      (off_full[4:0]),
            .wdata    (bus_wdata),
            .inj_en   (inj_valid && (inj_grp == GW'(g))),
            .inj_mask (inj_mask),
            .rdata    (grd[g]),
            .mismatch (mismatch[g])
        );
    end

    csg_irq #(.NGRP(NGRP)) u_irq (
        .clk         (clk),
        .rst         (rst),
        .raw_set_wr  (bus_wr && bus_addr == A_RAW),
        .pend_clr_wr (bus_wr && bus_addr == A_PEND),
        .en_set_wr   (bus_wr && bus_addr == A_EN),
        .wbits       (bus_wdata[NGRP-1:0]),
        .mismatch    (mismatch),
        .raw_q       (raw_q),
        .en_q        (en_q),
        .level       (cfg_irq_level),
        .pulse       (cfg_irq_pulse)
    );

    always_comb begin
        if (in_win)                 bus_rdata = grd[widx];
        else if (bus_addr == A_RAW)  bus_rdata = DW'(raw_q);
        else if (bus_addr == A_PEND) bus_rdata = DW'(raw_q & en_q);
        else if (bus_addr == A_EN)   bus_rdata = DW'(en_q);
        else                        bus_rdata = '0;
    end

endmodule

// File: rtl/csg_checker.sv
module csg_checker #(
    parameter int NGRP = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [NGRP-1:0] raw_q,
    input logic [NGRP-1:0] en_q,
    input logic [NGRP-1:0] mismatch,
    input logic            level,
    input logic            pulse
);

    a_r8_pulse_with_level: assert property (@(posedge clk) disable iff (rst)
        pulse |-> level);

    a_r8_rise_pulses: assert property (@(posedge clk) disable iff (rst)
        $rose(level) |-> pulse);

    a_r6_live_mismatch_wins: assert property (@(posedge clk) disable iff (rst)
        (mismatch != '0) |=> ((raw_q & $past(mismatch)) == $past(mismatch)));

    a_r4_enable_sticky: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((en_q & $past(en_q)) == $past(en_q)));

endmodule

bind cfg_shadow_guard csg_checker #(.NGRP(NGRP)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .raw_q    (raw_q),
    .en_q     (en_q),
    .mismatch (mismatch),
    .level    (cfg_irq_level),
    .pulse    (cfg_irq_pulse)
);

// File: tb/test_cfg_shadow_guard.sv
module test_cfg_shadow_guard;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        string       tag;
        logic [31:0] addr;
        logic [31:0] exp_rd;
        logic        exp_lvl;
        logic        exp_pls;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        inj_valid = 1'b0;
    logic [1:0]  inj_grp = '0;
    logic [31:0] inj_mask = '0;
    logic        cfg_irq_level, cfg_irq_pulse;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_shadow_guard i_cfg_shadow_guard (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .inj_valid(inj_valid),
        .inj_grp(inj_grp), .inj_mask(inj_mask),
        .cfg_irq_level(cfg_irq_level), .cfg_irq_pulse(cfg_irq_pulse)
    );

    task automatic quiet();
        bus_wr = 1'b0; inj_valid = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        quiet();
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic inject(input logic [1:0] g, input logic [31:0] m);
        @(posedge clk); #1;
        quiet();
        inj_valid = 1'b1; inj_grp = g; inj_mask = m;
    endtask

    task automatic wr_inj(input logic [11:0] a, input logic [31:0] d,
                          input logic [1:0] g, input logic [31:0] m);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        inj_valid = 1'b1; inj_grp = g; inj_mask = m;
    endtask

    task automatic idle();
        @(posedge clk); #1;
        quiet();
    endtask

    task automatic chk(input logic [11:0] a, input logic [31:0] rd,
                       input logic lvl, input logic pls, input string tag);
        item_t it;
        @(posedge clk); #1;
        quiet();
        bus_addr = a;
        it.tag = tag; it.addr = {20'd0, a}; it.exp_rd = rd;
        it.exp_lvl = lvl; it.exp_pls = pls;
        sb.push_back(it);
    endtask

    // monitor: compare queued expectations on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_vec++;
                if (bus_rdata !== it.exp_rd || cfg_irq_level !== it.exp_lvl ||
                    cfg_irq_pulse !== it.exp_pls) begin
                    n_bad++;
                    $display("FAIL %s addr=%h: actual rd=%h lvl=%b pls=%b expected rd=%h lvl=%b pls=%b",
                             it.tag, it.addr, bus_rdata, cfg_irq_level, cfg_irq_pulse,
                             it.exp_rd, it.exp_lvl, it.exp_pls);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        chk(12'h010, 32'h0, 1'b0, 1'b0, "R1 raw");
        chk(12'h408, 32'h0, 1'b0, 1'b0, "R1 group enable");

        wr(12'h408, 32'h0000_00F0);
        wr(12'h40C, 32'h0000_0030);
        chk(12'h408, 32'h0000_00C0, 1'b0, 1'b0, "R2 enable set/clear");
        chk(12'h40C, 32'h0000_00C0, 1'b0, 1'b0, "R2 enable via clear addr");
        wr(12'h434, 32'h0000_FF00);
        wr(12'h438, 32'h0000_0F00);
        chk(12'h434, 32'h0000_F000, 1'b0, 1'b0, "R2 pin influence");
        wr(12'h450, 32'h0000_0005);
        chk(12'h450, 32'h0000_0005, 1'b0, 1'b0, "R2 priority");
        wr(12'h460, 32'h0000_0003);
        wr(12'h460, 32'h0000_0004);
        chk(12'h460, 32'h0000_0007, 1'b0, 1'b0, "R2 event or");
        chk(12'h010, 32'h0, 1'b0, 1'b0, "R2 no false mismatch");

        inject(2'd1, 32'h0000_0001);
        idle();
        chk(12'h010, 32'h2, 1'b0, 1'b0, "R3 R7 raw set, disabled");
        chk(12'h014, 32'h0, 1'b0, 1'b0, "R7 masked status");

        wr(12'h018, 32'h2);
        chk(12'h014, 32'h2, 1'b1, 1'b1, "R4 R8 enable raises");
        chk(12'h018, 32'h2, 1'b1, 1'b0, "R8 pulse one clock");

        wr(12'h014, 32'h2);
        chk(12'h010, 32'h2, 1'b1, 1'b1, "R6 R9 clear loses to live mismatch");

        wr(12'h428, 32'h0);
        wr(12'h014, 32'h2);
        chk(12'h010, 32'h0, 1'b0, 1'b0, "R5 R9 healed and cleared");

        wr(12'h010, 32'h1);
        chk(12'h010, 32'h1, 1'b0, 1'b0, "R10 raw set write");
        wr(12'h018, 32'h1);
        chk(12'h014, 32'h1, 1'b1, 1'b1, "R10 R8 enable pending");
        wr(12'h010, 32'h2);
        chk(12'h014, 32'h3, 1'b1, 1'b0, "R8 no re-pulse");
        wr(12'h014, 32'h1);
        chk(12'h014, 32'h2, 1'b1, 1'b1, "R9 others remain");
        wr(12'h014, 32'h2);
        chk(12'h014, 32'h0, 1'b0, 1'b0, "R9 last cleared");

        wr_inj(12'h468, 32'h5, 2'd3, 32'h0000_0010);
        idle();
        chk(12'h010, 32'h8, 1'b0, 1'b0, "R11 R3 collision keeps mismatch");
        chk(12'h468, 32'h5, 1'b0, 1'b0, "R11 primary holds written value");
        wr(12'h46C, 32'h0);
        wr(12'h014, 32'h8);
        chk(12'h010, 32'h0, 1'b0, 1'b0, "R5 group 3 healed");
        chk(12'h018, 32'h3, 1'b0, 1'b0, "R4 enable read");

        idle();
        idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule